// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves and restores CPU context when an interrupt is taken or when its service routine returns. An entry strobe latches the programme counter, both index registers, both accumulators, the condition code byte, the stack pointer and the vector address. The block then writes the nine context bytes to a byte-wide stack memory, one byte per clock, moving downward from the stack pointer. It sets the interrupt mask bits in its own copy of the condition codes, and fetches the new programme counter from the vector table as two one-byte reads.

A return strobe runs the reverse walk. The block reads the same nine bytes upward from the stack pointer and rebuilds every register from them. This includes the condition code byte, so both mask bits return to the values they had before the interrupt. The processor core around the block decodes instructions, arbitrates between interrupt sources and supplies the vector address. It takes the restored register values from the outputs when the one-cycle done pulse appears.

Top module: `irq_ctx_stacker`

## Requirements
- R1: On entry, with latched stack pointer S, the bytes written are: S gets PC low, S-1 PC high, S-2 IY low, S-3 IY high, S-4 IX low, S-5 IX high, S-6 accumulator A, S-7 accumulator B, S-8 the condition codes. Addresses wrap modulo 2^16.
- R2: Entry performs exactly nine memory writes in nine consecutive cycles, one byte each. The write enable and the read strobe are never high in the same cycle.
- R3: When entry completes, outSp equals S-9 (modulo 2^16).
- R4: The condition code byte written to the stack is the unmodified input value. Only after that write does outCcr get bit 4 (the global mask) set. Bit 6 (the X mask) is set only when xSrc was high at entry. All other bits are unchanged.
- R5: After stacking, the block reads the high byte of the new PC at vecAddr and the low byte at vecAddr+1. Read data arrives one cycle after the read strobe, and outPc holds the fetched word at done.
- R6: On return, with latched stack pointer S, the block reads S+1 through S+9 in that order. It restores CCR, B, A, IX high, IX low, IY high, IY low, PC high and PC low from those bytes. outSp ends at S+9, and outCcr reproduces the stacked byte exactly, both mask bits included.
- R7: startReq and rtiReq are ignored while busy is high. The running sequence and its results are unaffected by them.
- R8: done is a one-cycle pulse. It occurs 12 cycles after the edge that accepts an entry strobe and 10 cycles after the edge that accepts a return strobe.
- R9: After reset, busy, done, memWe and memRe are low and all register outputs are zero.
- R10: If startReq and rtiReq are both high in an idle cycle, the entry sequence is run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin interrupt entry (sampled when idle) |
| rtiReq | input | 1 | Begin return from interrupt (sampled when idle) |
| xSrc | input | 1 | Accepted source is the X-gated one |
| vecAddr | input | 16 | Address of the winning vector entry |
| regPc | input | 16 | Programme counter to save |
| regIx | input | 16 | Index register X to save |
| regIy | input | 16 | Index register Y to save |
| regA | input | 8 | Accumulator A to save |
| regB | input | 8 | Accumulator B to save |
| regCcr | input | 8 | Condition codes to save |
| spIn | input | 16 | Stack pointer at strobe time |
| memRdata | input | 8 | Read data, valid one cycle after memRe |
| memAddr | output | 16 | Memory byte address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read strobe |
| outPc | output | 16 | New or restored programme counter |
| outIx | output | 16 | Restored index X |
| outIy | output | 16 | Restored index Y |
| outA | output | 8 | Restored accumulator A |
| outB | output | 8 | Restored accumulator B |
| outCcr | output | 8 | Condition codes after masking or restore |
| outSp | output | 16 | Stack pointer after the sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench uses the default parameters: a 16-bit address, 8-bit bytes, the global mask at bit 4 and the X mask at bit 6. These values fix the nine-byte frame at the two-byte register split used in the requirements. A stack pointer just above zero makes the push wrap through the top of the address space, and the pop then wraps back. Starting each return from the stack pointer the entry produced tests the round trip, including mask bits that were clear before entry and set during service.

// File: rtl/irq_stk_pkg.sv
package irq_stk_pkg;
  localparam int IDXW = 4;
  localparam int NBYTES = 9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_VWAIT, ST_POP, ST_PWAIT
  } seqState_t;

  typedef struct packed {
    logic            load;
    logic            pushEn;
    logic [IDXW-1:0] pushK;
    logic            setMask;
    logic            setX;
    logic            spPushDone;
    logic            vecRd;
    logic            vecLo;
    logic            capHi;
    logic            capLo;
    logic            popRd;
    logic [IDXW-1:0] popJ;
    logic            capEn;
    logic [IDXW-1:0] capK;
    logic            spPopDone;
  } ctlStrb_t;
endpackage

// File: rtl/irq_stk_ctrl.sv
module irq_stk_ctrl
  import irq_stk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     rtiReq,
  input  logic     xSrc,
  output ctlStrb_t strb,
  output logic     busy,
  output logic     done
);
  localparam logic [IDXW-1:0] LAST = IDXW'(NBYTES - 1);

  seqState_t       state;
  logic [IDXW-1:0] idx;
  logic            xLatch;
  logic            capV;
  logic [IDXW-1:0] capKq;

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      xLatch <= 1'b0;
      capV   <= 1'b0;
      capKq  <= '0;
      done   <= 1'b0;
    end else begin
      done  <= (state == ST_VWAIT) || (state == ST_PWAIT);
      capV  <= (state == ST_POP);
      capKq <= LAST - idx;
      unique case (state)
        ST_IDLE: begin
          idx <= '0;
          if (startReq) begin
            state  <= ST_PUSH;
            xLatch <= xSrc;
          end else if (rtiReq) begin
            state <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (idx == LAST) begin
            state <= ST_VHI;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_VHI:   state <= ST_VLO;
        ST_VLO:   state <= ST_VWAIT;
        ST_VWAIT: state <= ST_IDLE;
        ST_POP: begin
          if (idx == LAST) begin
            state <= ST_PWAIT;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_PWAIT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE:  strb.load = startReq | rtiReq;
      ST_PUSH: begin
        strb.pushEn = 1'b1;
        strb.pushK  = idx;
        if (idx == LAST) begin
          strb.setMask    = 1'b1;
          strb.setX       = xLatch;
          strb.spPushDone = 1'b1;
        end
      end
      ST_VHI: strb.vecRd = 1'b1;
      ST_VLO: begin
        strb.vecRd = 1'b1;
        strb.vecLo = 1'b1;
        strb.capHi = 1'b1;
      end
      ST_VWAIT: strb.capLo = 1'b1;
      ST_POP: begin
        strb.popRd = 1'b1;
        strb.popJ  = idx;
        strb.capEn = capV;
        strb.capK  = capKq;
      end
      ST_PWAIT: begin
        strb.capEn     = capV;
        strb.capK      = capKq;
        strb.spPopDone = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  // done is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // a strobe seen while busy never restarts the sequence
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_VWAIT && state != ST_PWAIT) |=> busy);
endmodule

// File: rtl/irq_stk_dp.sv
module irq_stk_dp
  import irq_stk_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int IBIT = 4,
  parameter int XBIT = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrb_t        strb,
  input  logic [AW-1:0]   vecAddr,
  input  logic [2*DW-1:0] regPc,
  input  logic [2*DW-1:0] regIx,
  input  logic [2*DW-1:0] regIy,
  input  logic [DW-1:0]   regA,
  input  logic [DW-1:0]   regB,
  input  logic [DW-1:0]   regCcr,
  input  logic [AW-1:0]   spIn,
  input  logic [DW-1:0]   memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  output logic            memWe,
  output logic            memRe,
  output logic [2*DW-1:0] outPc,
  output logic [2*DW-1:0] outIx,
  output logic [2*DW-1:0] outIy,
  output logic [DW-1:0]   outA,
  output logic [DW-1:0]   outB,
  output logic [DW-1:0]   outCcr,
  output logic [AW-1:0]   outSp
);
  localparam logic [AW-1:0] FRAME = AW'(NBYTES);

  logic [AW-1:0] vecQ;

  function automatic logic [DW-1:0] frameByte(input logic [IDXW-1:0] k,
      input logic [2*DW-1:0] pc, input logic [2*DW-1:0] ix,
      input logic [2*DW-1:0] iy, input logic [DW-1:0] a,
      input logic [DW-1:0] b, input logic [DW-1:0] ccr);
    unique case (k)
      4'd0:    frameByte = pc[DW-1:0];
      4'd1:    frameByte = pc[2*DW-1:DW];
      4'd2:    frameByte = iy[DW-1:0];
      4'd3:    frameByte = iy[2*DW-1:DW];
      4'd4:    frameByte = ix[DW-1:0];
      4'd5:    frameByte = ix[2*DW-1:DW];
      4'd6:    frameByte = a;
      4'd7:    frameByte = b;
      default: frameByte = ccr;
    endcase
  endfunction

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    memWe    = strb.pushEn;
    memRe    = strb.vecRd | strb.popRd;
    if (strb.pushEn) begin
      memAddr  = outSp - AW'(strb.pushK);
      memWdata = frameByte(strb.pushK, outPc, outIx, outIy, outA, outB, outCcr);
    end else if (strb.vecRd) begin
      memAddr = vecQ + AW'(strb.vecLo);
    end else if (strb.popRd) begin
      memAddr = outSp + AW'(strb.popJ) + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPc  <= '0;
      outIx  <= '0;
      outIy  <= '0;
      outA   <= '0;
      outB   <= '0;
      outCcr <= '0;
      outSp  <= '0;
      vecQ   <= '0;
    end else begin
      if (strb.load) begin
        outPc  <= regPc;
        outIx  <= regIx;
        outIy  <= regIy;
        outA   <= regA;
        outB   <= regB;
        outCcr <= regCcr;
        outSp  <= spIn;
        vecQ   <= vecAddr;
      end
      if (strb.setMask) begin
        outCcr[IBIT] <= 1'b1;
        if (strb.setX) outCcr[XBIT] <= 1'b1;
      end
      if (strb.spPushDone) outSp <= outSp - FRAME;
      if (strb.spPopDone)  outSp <= outSp + FRAME;
      if (strb.capHi) outPc[2*DW-1:DW] <= memRdata;
      if (strb.capLo) outPc[DW-1:0]    <= memRdata;
      if (strb.capEn) begin
        unique case (strb.capK)
          4'd0:    outPc[DW-1:0]    <= memRdata;
          4'd1:    outPc[2*DW-1:DW] <= memRdata;
          4'd2:    outIy[DW-1:0]    <= memRdata;
          4'd3:    outIy[2*DW-1:DW] <= memRdata;
          4'd4:    outIx[DW-1:0]    <= memRdata;
          4'd5:    outIx[2*DW-1:DW] <= memRdata;
          4'd6:    outA             <= memRdata;
          4'd7:    outB             <= memRdata;
          default: outCcr           <= memRdata;
        endcase
      end
    end
  end

  assert_we_re_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_push_down_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) - AW'(1)));

  assert_pop_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.popRd && $past(strb.popRd)) |-> (memAddr == $past(memAddr) + AW'(1)));

  assert_mask_after_stack_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.setMask |=> outCcr[IBIT]);
endmodule

// File: rtl/irq_ctx_stacker.sv
module irq_ctx_stacker
  import irq_stk_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int IBIT = 4,
  parameter int XBIT = 6
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            rtiReq,
  input  logic            xSrc,
  input  logic [AW-1:0]   vecAddr,
  input  logic [2*DW-1:0] regPc,
  input  logic [2*DW-1:0] regIx,
  input  logic [2*DW-1:0] regIy,
  input  logic [DW-1:0]   regA,
  input  logic [DW-1:0]   regB,
  input  logic [DW-1:0]   regCcr,
  input  logic [AW-1:0]   spIn,
  input  logic [DW-1:0]   memRdata,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata,
  output logic            memWe,
  output logic            memRe,
  output logic [2*DW-1:0] outPc,
  output logic [2*DW-1:0] outIx,
  output logic [2*DW-1:0] outIy,
  output logic [DW-1:0]   outA,
  output logic [DW-1:0]   outB,
  output logic [DW-1:0]   outCcr,
  output logic [AW-1:0]   outSp,
  output logic            busy,
  output logic            done
);
  ctlStrb_t strb;

  irq_stk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rtiReq(rtiReq),
    .xSrc(xSrc), .strb(strb), .busy(busy), .done(done)
  );

  irq_stk_dp #(.AW(AW), .DW(DW), .IBIT(IBIT), .XBIT(XBIT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .vecAddr(vecAddr),
    .regPc(regPc), .regIx(regIx), .regIy(regIy), .regA(regA), .regB(regB),
    .regCcr(regCcr), .spIn(spIn), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .outPc(outPc), .outIx(outIx), .outIy(outIy), .outA(outA), .outB(outB),
    .outCcr(outCcr), .outSp(outSp)
  );

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWe && !memRe));
endmodule

// File: tb/irq_ctx_stacker_tb.sv
module irq_ctx_stacker_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] pc, ix, iy;
    logic [7:0]  a, b, ccr;
    logic [15:0] sp, vec, tgt;
    logic        xs;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{16'h1234, 16'hA1A2, 16'hB1B2, 8'h11, 8'h22, 8'h00, 16'h01FF, 16'hFFF2, 16'h3000, 1'b0},
    '{16'hBEEF, 16'h0F0E, 16'h7788, 8'hC3, 8'h5A, 8'h0D, 16'h0123, 16'hFFF4, 16'h4567, 1'b1},
    '{16'h8001, 16'h1111, 16'h2222, 8'h33, 8'h44, 8'h81, 16'h0005, 16'hFFF6, 16'hC0DE, 1'b0},
    '{16'h0000, 16'hFFFF, 16'h00FF, 8'hFF, 8'h01, 8'h2A, 16'h0240, 16'hFFF0, 16'h9ABC, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 0, rtiReq = 0, xSrc = 0;
  logic [15:0] vecAddr = 0, regPc = 0, regIx = 0, regIy = 0, spIn = 0;
  logic [7:0] regA = 0, regB = 0, regCcr = 0, memRdata;
  logic [15:0] memAddr, outPc, outIx, outIy, outSp;
  logic [7:0] memWdata, outA, outB, outCcr;
  logic memWe, memRe, busy, done;

  logic [7:0] mem [1024];
  int wrCnt = 0;
  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctx_stacker u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rtiReq(rtiReq), .xSrc(xSrc),
    .vecAddr(vecAddr), .regPc(regPc), .regIx(regIx), .regIy(regIy),
    .regA(regA), .regB(regB), .regCcr(regCcr), .spIn(spIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .memRe(memRe), .outPc(outPc), .outIx(outIx),
    .outIy(outIy), .outA(outA), .outB(outB), .outCcr(outCcr),
    .outSp(outSp), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr[9:0]] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
    if (memRe) memRdata <= mem[memAddr[9:0]];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive strobes at a negedge, count cycles to done, then check done width (R8)
  task automatic runSeq(input bit st, input bit rt, output int n);
    @(negedge clk);
    startReq = st; rtiReq = rt;
    @(negedge clk);
    startReq = 0; rtiReq = 0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!done && n < 50);
    @(negedge clk);
    chk(!done, "R8 pulse", 32'(done), 0);
  endtask

  task automatic loadRegs(input vec_t v);
    regPc = v.pc; regIx = v.ix; regIy = v.iy; regA = v.a; regB = v.b;
    regCcr = v.ccr; spIn = v.sp; vecAddr = v.vec; xSrc = v.xs;
    mem[v.vec[9:0]] = v.tgt[15:8];
    mem[10'(v.vec + 16'd1)] = v.tgt[7:0];
  endtask

  task automatic checkFrame(input vec_t v);
    logic [7:0] exp [9];
    exp = '{v.pc[7:0], v.pc[15:8], v.iy[7:0], v.iy[15:8], v.ix[7:0],
            v.ix[15:8], v.a, v.b, v.ccr};
    for (int k = 0; k < 9; k++)
      chk(mem[10'(v.sp - 16'(k))] == exp[k], "R1 frame byte",
          32'(mem[10'(v.sp - 16'(k))]), 32'(exp[k]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !memWe && !memRe, "R9 ctl", {busy, done, memWe, memRe}, 0);
    chk(outPc == 0 && outSp == 0 && outCcr == 0 && outA == 0, "R9 regs", 32'(outPc), 0);
    rstN = 1;

    foreach (VECS[i]) begin
      vec_t v;
      logic [7:0] expCcr;
      v = VECS[i];
      loadRegs(v);
      wrCnt = 0;
      runSeq(1, 0, n);
      chk(n == 12, "R8 entry latency", 32'(n), 12);
      chk(wrCnt == 9, "R2 write count", 32'(wrCnt), 9);
      checkFrame(v);
      chk(outSp == v.sp - 16'd9, "R3 sp", 32'(outSp), 32'(v.sp - 16'd9));
      expCcr = v.ccr | 8'h10 | (v.xs ? 8'h40 : 8'h00);
      chk(outCcr == expCcr, "R4 mask", 32'(outCcr), 32'(expCcr));
      chk(outPc == v.tgt, "R5 vector", 32'(outPc), 32'(v.tgt));
      // return: scramble inputs, pop from the post-entry pointer
      regPc = 16'hDEAD; regIx = 0; regIy = 0; regA = 0; regB = 0; regCcr = 8'hFF;
      spIn = outSp;
      wrCnt = 0;
      runSeq(0, 1, n);
      chk(n == 10, "R8 return latency", 32'(n), 10);
      chk(wrCnt == 0, "R6 no writes", 32'(wrCnt), 0);
      chk(outCcr == v.ccr, "R6 ccr", 32'(outCcr), 32'(v.ccr));
      chk(outPc == v.pc, "R6 pc", 32'(outPc), 32'(v.pc));
      chk(outIx == v.ix && outIy == v.iy, "R6 index", {outIx, outIy}, {v.ix, v.iy});
      chk(outA == v.a && outB == v.b, "R6 acc", {outA, outB}, {v.a, v.b});
      chk(outSp == v.sp, "R6 sp", 32'(outSp), 32'(v.sp));
    end

    // R10: both strobes together in idle -> entry
    loadRegs(VECS[1]);
    wrCnt = 0;
    runSeq(1, 1, n);
    chk(n == 12 && wrCnt == 9, "R10 entry wins", 32'(n), 12);
    chk(outPc == VECS[1].tgt, "R10 pc", 32'(outPc), 32'(VECS[1].tgt));

    // R7: strobes while busy are ignored
    loadRegs(VECS[0]);
    wrCnt = 0;
    @(negedge clk);
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    repeat (3) @(negedge clk);
    spIn = 16'h0300; regPc = 16'h5555; startReq = 1; rtiReq = 1;
    @(negedge clk);
    startReq = 0; rtiReq = 0;
    n = 4;
    while (!done && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk(n == 12, "R7 latency unchanged", 32'(n), 12);
    chk(outSp == VECS[0].sp - 16'd9, "R7 sp", 32'(outSp), 32'(VECS[0].sp - 16'd9));
    chk(outPc == VECS[0].tgt, "R7 pc", 32'(outPc), 32'(VECS[0].tgt));
    checkFrame(VECS[0]);
    @(negedge clk);
    chk(!busy && wrCnt == 9, "R7 no restart", {busy, 8'(wrCnt)}, 9);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule